// File: doc/BRIEF.md
# Nibble Register-Bank Datapath

This block is the execution core of a very small processor. Four 4-bit storage registers feed two operand ports at once, each through its own select, and a purely combinational arithmetic and logic unit turns the two operands into a 4-bit result plus two status flags. At the rising clock edge the result is stored into the register named by the destination select, but only while the write-back enable is high.

The user drives the selects and the 4-bit operation code each cycle and reads back the operands, the result and the flags in the same cycle. The flags are combinational and are not held. A synchronous reset loads every register with a known start value, so useful arithmetic is possible before anything is written. Because the result feeds only the register bank, any constant has to be built from those start values with ordinary operations.

Top module: `nibble_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, registers 0, 1, 2 and 3 are loaded with 1, 2, 3 and 4.
- R2: `src_a` shows the register chosen by `src_a_sel` and `src_b` the one chosen by `src_b_sel`, combinationally and independently. The two selects may name the same register.
- R3: At a rising edge with `wb_en` high, the register chosen by `dst_sel` takes the value of `alu_out`. With `wb_en` low, no register changes.
- R4: When the destination register is also being read, the read port shows the old value until the edge and the new value after it.
- R5: Operation code 0000 adds. `alu_out` is the low 4 bits of the sum and `flag_carry` is the fifth bit of the sum.
- R6: Operation code 0001 computes `src_a - src_b` modulo 16. `flag_carry` is set when `src_a < src_b` (borrow).
- R7: Operation code 0010 multiplies. `alu_out` is the low nibble of the 8-bit product and `flag_carry` is set when the high nibble is nonzero.
- R8: Operation code 0011 divides with an integer quotient and clears the carry. A zero divisor gives `alu_out` = 4'hF with `flag_carry` set.
- R9: Operation codes 0100 (AND), 0101 (OR), 0110 (XOR), 0111 (XNOR) and 1000 (NOT of `src_a` only) give the bitwise result with `flag_carry` cleared.
- R10: Operation code 1001 shifts `src_a` right by one, filling with zero, and `flag_carry` is the old bit 0. Operation code 1010 shifts `src_a` left by one, filling with zero, and `flag_carry` is the old bit 3.
- R11: Operation codes 1011 to 1111 give `alu_out` = 0 with `flag_carry` cleared.
- R12: For every operation code, `flag_zero` is high exactly when `alu_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| src_a_sel | input | 2 | Register select for the first operand |
| src_b_sel | input | 2 | Register select for the second operand |
| dst_sel | input | 2 | Register select for write-back |
| wb_en | input | 1 | Write-back enable |
| op_code | input | 4 | Operation code |
| src_a | output | 4 | First operand value |
| src_b | output | 4 | Second operand value |
| alu_out | output | 4 | Operation result |
| flag_zero | output | 1 | Result is zero |
| flag_carry | output | 1 | Carry, borrow, overflow or shifted-out bit, depending on the operation |

## Verification
Write-back and operand read can hit the same register in one cycle: an add whose destination is also its first source. The bench sets this up for every one of the 256 operand pairs. It requires the read port to show the old value just before the edge and the computed sum just after it. Each pair is first built inside the bank using only the block's own operations. All sixteen operation codes are then swept with write-back off, and every result and flag is compared with values the bench computes arithmetically.

// File: rtl/nd_pkg.sv
`timescale 1ns/1ps
package nd_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_DIV  = 4'h3,
        OP_AND  = 4'h4,
        OP_OR   = 4'h5,
        OP_XOR  = 4'h6,
        OP_XNOR = 4'h7,
        OP_NOT  = 4'h8,
        OP_SHR  = 4'h9,
        OP_SHL  = 4'hA
    } alu_op_e;

endpackage

// File: rtl/nd_regbank.sv
`timescale 1ns/1ps
module nd_regbank #(
    parameter int WIDTH = 4,
    parameter int NREG  = 4,
    parameter int NRD   = 2,
    localparam int SELW = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NRD-1:0][SELW-1:0]   rd_sel,
    output logic [NRD-1:0][WIDTH-1:0]  rd_data,
    input  logic                       wr_en,
    input  logic [SELW-1:0]            wr_sel,
    input  logic [WIDTH-1:0]           wr_data
);

    typedef struct packed {
        logic [NREG-1:0][WIDTH-1:0] bank;
    } bank_state_t;

    bank_state_t st_d, st_q;

    function automatic logic [WIDTH-1:0] start_value(input int idx);
        return WIDTH'(idx + 1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                st_d.bank[i] = start_value(i);
            end
        end else if (wr_en) begin
            st_d.bank[wr_sel] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Read ports see only the registered state: old value until the edge (R4)
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = st_q.bank[rd_sel[p]];
    end

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        assert_reset_R1: assert property (@(posedge clk)
            rst |=> (st_q.bank[g] == start_value(g)));

        assert_write_R3: assert property (@(posedge clk) disable iff (rst)
            (wr_en && (wr_sel == SELW'(g))) |=> (st_q.bank[g] == $past(wr_data)));

        assert_keep_R3: assert property (@(posedge clk) disable iff (rst)
            (!wr_en || (wr_sel != SELW'(g))) |=> $stable(st_q.bank[g]));
    end

endmodule

// File: rtl/nd_alu.sv
`timescale 1ns/1ps
module nd_alu
    import nd_pkg::*;
#(
    parameter int WIDTH = 4,
    localparam int PW   = 2 * WIDTH
) (
    input  logic [OP_W-1:0]  op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] res,
    output logic             carry,
    output logic             zero
);

    typedef struct packed {
        logic [WIDTH-1:0] value;
        logic             carry;
    } alu_res_t;

    alu_res_t         out_d;
    logic [WIDTH:0]   sum_w;
    logic [WIDTH:0]   dif_w;
    logic [PW-1:0]    prod_w;
    logic [WIDTH-1:0] quot_w;
    logic             div_zero;

    always_comb begin
        sum_w    = {1'b0, a} + {1'b0, b};
        dif_w    = {1'b0, a} - {1'b0, b};
        prod_w   = {{WIDTH{1'b0}}, a} * {{WIDTH{1'b0}}, b};
        div_zero = (b == '0);
        quot_w   = div_zero ? '1 : (a / b);
    end

    always_comb begin
        out_d = '0;
        case (alu_op_e'(op))
            OP_ADD: begin
                out_d.value = sum_w[WIDTH-1:0];
                out_d.carry = sum_w[WIDTH];
            end
            OP_SUB: begin
                out_d.value = dif_w[WIDTH-1:0];
                out_d.carry = dif_w[WIDTH];
            end
            OP_MUL: begin
                out_d.value = prod_w[WIDTH-1:0];
                out_d.carry = |prod_w[PW-1:WIDTH];
            end
            OP_DIV: begin
                out_d.value = quot_w;
                out_d.carry = div_zero;
            end
            OP_AND:  out_d.value = a & b;
            OP_OR:   out_d.value = a | b;
            OP_XOR:  out_d.value = a ^ b;
            OP_XNOR: out_d.value = ~(a ^ b);
            OP_NOT:  out_d.value = ~a;
            OP_SHR: begin
                out_d.value = {1'b0, a[WIDTH-1:1]};
                out_d.carry = a[0];
            end
            OP_SHL: begin
                out_d.value = {a[WIDTH-2:0], 1'b0};
                out_d.carry = a[WIDTH-1];
            end
            default: out_d = '0;
        endcase
    end

    assign res   = out_d.value;
    assign carry = out_d.carry;
    assign zero  = (out_d.value == '0);

endmodule

// File: rtl/nibble_datapath.sv
`timescale 1ns/1ps
module nibble_datapath
    import nd_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int NREG  = 4,
    localparam int SELW = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SELW-1:0]  src_a_sel,
    input  logic [SELW-1:0]  src_b_sel,
    input  logic [SELW-1:0]  dst_sel,
    input  logic             wb_en,
    input  logic [OP_W-1:0]  op_code,
    output logic [WIDTH-1:0] src_a,
    output logic [WIDTH-1:0] src_b,
    output logic [WIDTH-1:0] alu_out,
    output logic             flag_zero,
    output logic             flag_carry
);

    localparam int NRD = 2;

    logic [NRD-1:0][SELW-1:0]  rd_sel_w;
    logic [NRD-1:0][WIDTH-1:0] rd_data_w;
    logic [WIDTH-1:0]          res_w;

    assign rd_sel_w = {src_b_sel, src_a_sel};
    assign src_a    = rd_data_w[0];
    assign src_b    = rd_data_w[1];
    assign alu_out  = res_w;

    nd_regbank #(
        .WIDTH (WIDTH),
        .NREG  (NREG),
        .NRD   (NRD)
    ) regbank_i (
        .clk     (clk),
        .rst     (rst),
        .rd_sel  (rd_sel_w),
        .rd_data (rd_data_w),
        .wr_en   (wb_en),
        .wr_sel  (dst_sel),
        .wr_data (res_w)
    );

    nd_alu #(
        .WIDTH (WIDTH)
    ) alu_i (
        .op    (op_code),
        .a     (rd_data_w[0]),
        .b     (rd_data_w[1]),
        .res   (res_w),
        .carry (flag_carry),
        .zero  (flag_zero)
    );

    assert_divzero_R8: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_DIV && src_b == '0) |-> (alu_out == '1 && flag_carry));

    assert_borrow_R6: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_SUB) |-> (flag_carry == (src_a < src_b)));

    assert_shl_out_R10: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_SHL) |-> ({flag_carry, alu_out} == {src_a, 1'b0}));

    assert_unused_R11: assert property (@(posedge clk) disable iff (rst)
        (op_code > OP_SHL) |-> (alu_out == '0 && !flag_carry && flag_zero));

    assert_logic_nocarry_R9: assert property (@(posedge clk) disable iff (rst)
        (op_code >= OP_AND && op_code <= OP_NOT) |-> !flag_carry);

endmodule

// File: tb/nibble_datapath_tb.sv
`timescale 1ns/1ps
module nibble_datapath_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] src_a_sel, src_b_sel, dst_sel;
    logic       wb_en;
    logic [3:0] op_code;
    logic [3:0] src_a, src_b, alu_out;
    logic       flag_zero, flag_carry;

    int checks = 0;
    int errors = 0;
    int mreg [4];

    always #4 clk = ~clk;

    nibble_datapath dut_i (
        .clk        (clk),
        .rst        (rst),
        .src_a_sel  (src_a_sel),
        .src_b_sel  (src_b_sel),
        .dst_sel    (dst_sel),
        .wb_en      (wb_en),
        .op_code    (op_code),
        .src_a      (src_a),
        .src_b      (src_b),
        .alu_out    (alu_out),
        .flag_zero  (flag_zero),
        .flag_carry (flag_carry)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic void model(input int op, input int a, input int b,
                                  output int r, output int c);
        int t;
        r = 0; c = 0;
        case (op)
            0: begin t = a + b; r = t % 16; c = t / 16; end
            1: begin r = (a - b + 16) % 16; c = (a < b) ? 1 : 0; end
            2: begin t = a * b; r = t % 16; c = (t / 16 != 0) ? 1 : 0; end
            3: begin if (b == 0) begin r = 15; c = 1; end else r = a / b; end
            4: r = a & b;
            5: r = a | b;
            6: r = a ^ b;
            7: r = 15 - (a ^ b);
            8: r = 15 - a;
            9: begin r = a / 2; c = a % 2; end
            10: begin r = (a * 2) % 16; c = a / 8; end
            default: begin r = 0; c = 0; end
        endcase
    endfunction

    function automatic string req_of(input int op);
        if (op == 0) return "R5";
        if (op == 1) return "R6";
        if (op == 2) return "R7";
        if (op == 3) return "R8";
        if (op <= 8) return "R9";
        if (op <= 10) return "R10";
        return "R11";
    endfunction

    task automatic do_op(input int a, input int b, input int d, input bit we, input int op);
        int r, c;
        @(negedge clk);
        src_a_sel = 2'(a); src_b_sel = 2'(b); dst_sel = 2'(d);
        wb_en = we; op_code = 4'(op);
        model(op, mreg[a], mreg[b], r, c);
        @(posedge clk);
        if (we) mreg[d] = r;
        #1;
        wb_en = 1'b0;
    endtask

    // builds value v in register k using register 3 (holding 1)
    task automatic set_reg(input int k, input int v);
        do_op(k, k, k, 1, 6);
        for (int i = 3; i >= 0; i--) begin
            do_op(k, k, k, 1, 10);
            if (((v >> i) & 1) == 1) do_op(k, 3, k, 1, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; wb_en = 1'b0; op_code = 4'h0;
        src_a_sel = 2'd0; src_b_sel = 2'd0; dst_sel = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) mreg[i] = i + 1;

        // R1 reset values, R2 both ports independently
        for (int i = 0; i < 4; i++) begin
            src_a_sel = 2'(i); src_b_sel = 2'(3 - i); #1;
            check("R1 reset value port a", int'(src_a), i + 1);
            check("R2 port b", int'(src_b), 4 - i);
        end

        // make register 3 hold 1: 4 >> 1 >> 1
        do_op(3, 3, 3, 1, 9);
        do_op(3, 3, 3, 1, 9);
        @(negedge clk); src_a_sel = 2'd3; #1;
        check("R10 shift write-back", int'(src_a), 1);

        // R3 hold: wb_en low leaves all registers untouched
        for (int op = 0; op < 11; op++) do_op(0, 1, op % 4, 0, op);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            src_a_sel = 2'(i); #1;
            check("R3 hold with wb_en low", int'(src_a), mreg[i]);
        end

        // full operand sweep
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                set_reg(0, a);
                set_reg(1, b);
                @(negedge clk);
                src_a_sel = 2'd0; src_b_sel = 2'd1; wb_en = 1'b0; #1;
                check("R2 R3 operand a", int'(src_a), a);
                check("R2 R3 operand b", int'(src_b), b);
                for (int op = 0; op < 16; op++) begin
                    int r, c;
                    op_code = 4'(op); #0.2;
                    model(op, a, b, r, c);
                    check({req_of(op), " result"}, int'(alu_out), r);
                    check({req_of(op), " carry"}, int'(flag_carry), c);
                    check("R12 zero flag", int'(flag_zero), (r == 0) ? 1 : 0);
                end
                // R4: r0 = r0 + r1 while r0 is read
                @(negedge clk);
                src_a_sel = 2'd0; src_b_sel = 2'd1; dst_sel = 2'd0;
                op_code = 4'h0; wb_en = 1'b1; #1;
                check("R4 old value before edge", int'(src_a), a);
                @(posedge clk); #1;
                wb_en = 1'b0;
                mreg[0] = (a + b) % 16;
                check("R4 new value after edge", int'(src_a), (a + b) % 16);
            end
        end

        // R1 again: reset mid-run restores start values
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            src_b_sel = 2'(i); #1;
            check("R1 reset reload", int'(src_b), i + 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule